// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a 6-bit successive-approximation analog-to-digital converter. An external DAC is driven from `trial_o`. An external comparator reports back on `cmp_i` whether the DAC level is above the unknown input. The block holds the approximation register and runs the bit trials, most significant bit first. It signals completion on an active-low end-of-conversion flag and presents the result on a data bus whose drivers are enabled by an active-low output-enable pin.

A conversion is requested by a START pulse while chip select is low. START acts as a reset of the register for as long as it is held high. The trials begin on the first clock edge that samples START low again. One bit is settled per edge, and each bit appears on the data bus as soon as it is settled, so a partial code can be watched while the conversion runs. The flag drops on the eighth edge after START and stays low until the result is read by pulling output enable low.

All register activity happens on the rising edge of `clk`. Reset is synchronous and active high.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `eoc_n_o` is 1, `data_o` is 0 and `trial_o` is 0.
- R2: An edge that samples `start_i`=1 with `cs_n_i`=0 clears the register (`data_o`=0) and sets `eoc_n_o` to 1. When `cs_n_i`=1, `start_i` has no effect on `data_o` or `eoc_n_o`.
- R3: Counting the edges that sample `start_i` low after an accepted START, edge k (k=1..6) settles bit 6-k. Before edge k, `trial_o` equals the bits already settled, with bit 6-k also set to 1 and the lower bits at 0.
- R4: On a trial edge, the bit under test is cleared if `cmp_i`=1 (DAC above input) and kept at 1 otherwise. After the conversion, `data_o` equals the input code for every code 0..63.
- R5: Each settled bit is visible on `data_o` right after its trial edge. For example, after edge 1, `data_o[5]` already holds the final MSB.
- R6: `eoc_n_o` stays 1 through edge 7 and goes to 0 on edge 8 after START is sampled low.
- R7: While `eoc_n_o`=0, it stays 0 as long as `oe_n_i`=1. The first edge that samples `oe_n_i`=0 returns it to 1.
- R8: `data_en_o` is 1 exactly when `oe_n_i` is 0. The bus is undriven while `data_en_o` is 0.
- R9: An input at or above full scale (a comparator that never reports the DAC above the input) yields 6'b111111.
- R10: A START accepted during a conversion aborts that conversion. The register is cleared, `eoc_n_o` returns to 1, and a full new conversion follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n_i | input | 1 | Chip select, active low, gates START |
| start_i | input | 1 | Conversion request; held high, it resets the register |
| cmp_i | input | 1 | Comparator: 1 when the DAC level exceeds the input |
| oe_n_i | input | 1 | Output enable / read strobe, active low |
| trial_o | output | 6 | Code presented to the external DAC |
| data_o | output | 6 | Approximation register contents (result bus value) |
| data_en_o | output | 1 | Tri-state driver enable for `data_o` |
| eoc_n_o | output | 1 | End of conversion, active low |

## Verification
The bench drives all 64 input codes plus several levels above full scale through an ideal comparator model. A wrong trial order or an inverted decision shows up as a wrong result code, and a saturation fault shows up as a code other than all ones. It samples the flag on edges 7 and 8 to catch an off-by-one completion count, and it holds output enable high for several cycles to catch a flag that clears on its own. A START with chip select high must leave a finished result and its flag untouched. A START in the middle of a conversion must restart the count rather than finish the old conversion early.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int unsigned CODE_W   = 6;
    localparam int unsigned DONE_STP = CODE_W + 1;
    localparam int unsigned STEP_W   = $clog2(DONE_STP + 1);
    localparam int unsigned IDX_W    = $clog2(CODE_W);

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic             clear;
        logic             trying;
        logic             decide;
        logic [IDX_W-1:0] idx;
        logic             done;
    } ctl_s;

endpackage

// File: rtl/sar_ctl.sv
module sar_ctl
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic cs_n_i,
    output ctl_s ctl_o
);

    phase_e              phase_q;
    logic [STEP_W-1:0]   step_q;
    logic                accept;

    assign accept = start_i & ~cs_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
        end else if (accept) begin
            phase_q <= PH_RUN;
            step_q  <= '0;
        end else if (phase_q == PH_RUN) begin
            if (step_q == STEP_W'(DONE_STP)) begin
                phase_q <= PH_IDLE;
                step_q  <= '0;
            end else begin
                step_q  <= step_q + 1'b1;
            end
        end
    end

    always_comb begin
        ctl_o.clear  = accept;
        ctl_o.trying = (phase_q == PH_RUN) && (step_q < STEP_W'(CODE_W));
        ctl_o.decide = ctl_o.trying && !accept;
        ctl_o.idx    = IDX_W'(CODE_W - 1) - IDX_W'(step_q);
        ctl_o.done   = (phase_q == PH_RUN) && !accept && (step_q == STEP_W'(DONE_STP));
    end

    // R6: completion only follows a full run of trial steps
    a_r6_done_after_last_trial: assert property (@(posedge clk) disable iff (rst)
        ctl_o.done |-> $past(phase_q == PH_RUN));

    // R10: an accepted START always restarts the step count
    a_r10_restart_count: assert property (@(posedge clk) disable iff (rst)
        accept |=> (step_q == '0 && phase_q == PH_RUN));

endmodule

// File: rtl/sar_reg.sv
module sar_reg
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_s              ctl_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] sar_o,
    output logic [CODE_W-1:0] trial_o
);

    logic [CODE_W-1:0] sar_q;
    logic [CODE_W-1:0] probe;

    always_comb begin
        probe = '0;
        if (ctl_i.trying) probe[ctl_i.idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl_i.clear) begin
            sar_q <= '0;
        end else if (ctl_i.decide) begin
            sar_q[ctl_i.idx] <= ~cmp_i;
        end
    end

    assign sar_o   = sar_q;
    assign trial_o = sar_q | probe;

    // R2: an accepted START empties the register
    a_r2_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        ctl_i.clear |=> (sar_o == '0));

    // R3: at most one bit of the register moves per edge outside a clear
    a_r3_one_bit_per_edge: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.clear && !$past(ctl_i.clear)) |-> ($countones(sar_o ^ $past(sar_o)) <= 1));

    // R4: a trial keeps the bit under test only when the comparator says the DAC is not above
    a_r4_decision: assert property (@(posedge clk) disable iff (rst)
        ctl_i.decide |=> (sar_o[$past(ctl_i.idx)] == !$past(cmp_i)));

endmodule

// File: rtl/sar_flag.sv
module sar_flag
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_s ctl_i,
    input  logic oe_n_i,
    output logic eoc_n_o
);

    logic eoc_n_q;

    always_ff @(posedge clk) begin
        if (rst || ctl_i.clear) begin
            eoc_n_q <= 1'b1;
        end else if (ctl_i.done) begin
            eoc_n_q <= 1'b0;
        end else if (!eoc_n_q && !oe_n_i) begin
            eoc_n_q <= 1'b1;
        end
    end

    assign eoc_n_o = eoc_n_q;

    // R7: a read strobe releases the flag on the next edge
    a_r7_read_releases: assert property (@(posedge clk) disable iff (rst)
        (!eoc_n_o && !oe_n_i && !ctl_i.done) |=> eoc_n_o);

    // R7: without a read or a new START the flag holds low
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (!eoc_n_o && oe_n_i && !ctl_i.clear) |=> !eoc_n_o);

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              start_i,
    input  logic              cmp_i,
    input  logic              oe_n_i,
    output logic [CODE_W-1:0] trial_o,
    output logic [CODE_W-1:0] data_o,
    output logic              data_en_o,
    output logic              eoc_n_o
);

    ctl_s ctl;

    sar_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cs_n_i  (cs_n_i),
        .ctl_o   (ctl)
    );

    sar_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .cmp_i   (cmp_i),
        .sar_o   (data_o),
        .trial_o (trial_o)
    );

    sar_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .oe_n_i  (oe_n_i),
        .eoc_n_o (eoc_n_o)
    );

    assign data_en_o = ~oe_n_i;

    // R2: with chip select high, START leaves a finished result alone
    a_r2_deselected_start: assert property (@(posedge clk) disable iff (rst)
        (cs_n_i && start_i && !eoc_n_o) |=> $stable(data_o));

endmodule

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b0;
    logic       start = 1'b0;
    logic       oe_n = 1'b1;
    logic       cmp;
    logic [5:0] trial;
    logic [5:0] data;
    logic       data_en;
    logic       eoc_n;
    int         vin = 0;

    int errors = 0;
    int checks = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    // ideal DAC and comparator
    assign cmp = (int'(trial) > vin);

    sar_conv_ctrl i_sar_conv_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_n_i    (cs_n),
        .start_i   (start),
        .cmp_i     (cmp),
        .oe_n_i    (oe_n),
        .trial_o   (trial),
        .data_o    (data),
        .data_en_o (data_en),
        .eoc_n_o   (eoc_n)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each falling edge of the flag
    logic prev_eoc = 1'b1;
    always @(negedge clk) begin
        if (!rst && prev_eoc && !eoc_n) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected completion", 1, 0);
            end else begin
                chk("R4/R9 result", int'(data), exp_q.pop_front());
            end
        end
        prev_eoc <= eoc_n;
    end

    task automatic read_out(int wait_cyc);
        for (int i = 0; i < wait_cyc; i++) begin
            @(negedge clk);
            chk("R7 flag holds while oe_n high", int'(eoc_n), 0);
        end
        oe_n = 1'b0;
        #1 chk("R8 driver enabled", int'(data_en), 1);
        @(negedge clk);
        chk("R7 flag released by read", int'(eoc_n), 1);
        oe_n = 1'b1;
        #1 chk("R8 driver disabled", int'(data_en), 0);
    endtask

    task automatic run_conv(int v, int exp);
        vin = v;
        exp_q.push_back(exp);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 register cleared", int'(data), 0);
        chk("R2 flag high after START", int'(eoc_n), 1);
        chk("R3 first trial code", int'(trial), 32);
        @(negedge clk);
        chk("R5 MSB visible after edge 1", int'(data[5]), (v >= 32) ? 1 : 0);
        chk("R3 second trial code", int'(trial), ((v >= 32) ? 32 : 0) + 16);
        for (int e = 2; e <= 7; e++) begin
            @(negedge clk);
            chk("R6 flag high before edge 8", int'(eoc_n), 1);
        end
        @(negedge clk);
        chk("R6 flag low on edge 8", int'(eoc_n), 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset eoc_n", int'(eoc_n), 1);
        chk("R1 reset data", int'(data), 0);
        chk("R1 reset trial", int'(trial), 0);
        chk("R8 reset enable", int'(data_en), 0);

        // R4: every code
        for (int c = 0; c < 64; c++) begin
            run_conv(c, c);
            read_out((c % 4 == 0) ? 3 : 0);
        end

        // R9: at and above full scale
        run_conv(63, 63);
        read_out(0);
        run_conv(70, 63);
        read_out(0);
        run_conv(1000, 63);

        // R2: START with chip select high is ignored
        cs_n = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 ignored START keeps data", int'(data), 63);
            chk("R2 ignored START keeps flag", int'(eoc_n), 0);
        end
        cs_n = 1'b0;
        read_out(0);

        // R10: abort mid conversion and restart
        vin = 10;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        run_conv(50, 50);
        chk("R10 restarted result", int'(data), 50);
        read_out(1);

        // R10: abort after completion but before read
        run_conv(5, 5);
        run_conv(41, 41);
        read_out(0);

        repeat (3) @(negedge clk);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule